// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from six sources on behalf of a small 8-bit processor core. It latches each request into a pending flag, lets software mask each source and the whole block, and decides which pending, unmasked request to service. It then hands the core a vector address. Two sources are external pins. Each pin is resynchronised, and each has a configuration input that selects whether a rising or a falling transition counts as the request. The other four sources are single-cycle pulses: two timer overflows, a serial-transfer completion and a merged multi-function request.

Arbitration runs only on cycles that carry the core's phase strobe. Requests that arrive between two strobes wait in their flags and are judged together on the later strobe. When a request is accepted, the block does three things in one step: it clears that source's flag, it drops the global enable, and it pulses a vector to the core. A push acknowledge follows one cycle later. The global enable comes back with a return-from-interrupt strobe, or when software writes it. A plain return does not restore it. While the core reports that its call stack is full, no request is accepted.

Software sees all the state through two 8-bit registers. It reads them through a combinational read port and writes them through a single-cycle write strobe.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Vector addresses are 0x04 for external 0, 0x08 for external 1, 0x0C for timer 0, 0x10 for timer 1, 0x14 for serial and 0x18 for multi-function.
- R2: When several sources are pending and enabled, the order from most to least urgent is external 0, external 1, timer 0, timer 1, serial, multi-function. Exactly one source is taken per acceptance.
- R3: Register 0 (address 0): bit 0 global enable, bits 1/2/3 enables for external 0/external 1/timer 0, bits 4/5/6 flags for external 0/external 1/timer 0, bit 7 reads 0. Register 1 (address 1): bits 0/1/2 enables for timer 1/serial/multi-function, bits 4/5/6 flags for timer 1/serial/multi-function, bits 3 and 7 read 0. All listed bits are writable and read back.
- R4: A source is accepted only if its flag is set, its enable is set, the global enable is set and the stack-full input is low. Otherwise its flag stays set.
- R5: Acceptance clears the flag of the accepted source and clears the global enable. Other flags are untouched.
- R6: While the global enable is clear, requests still set their flags and stay pending without being serviced.
- R7: A return-from-interrupt strobe sets the global enable. A plain return strobe leaves it unchanged. A software write of bit 0 of register 0 sets it directly.
- R8: Arbitration happens only in a cycle where the phase strobe is high. Flags raised between strobes wait for the next strobe.
- R9: Each external input has a select bit: 1 means a rising transition sets the flag, 0 means a falling transition sets it. The other transition has no effect.
- R10: External inputs pass through two synchronising flops before edge detection. When a hardware request and a software write of 0 hit the same flag in the same cycle, the flag ends up set.
- R11: Acceptance shows as irq_valid_o high for exactly one cycle, with irq_vector_o valid in that cycle. irq_ack_o is high for exactly the following cycle.
- R12: After reset both registers read 0, and irq_valid_o and irq_ack_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 2 | External interrupt pins (bit 0 external 0, bit 1 external 1) |
| ext_rise_sel_i | input | 2 | Static edge select per pin: 1 rising, 0 falling |
| tmr0_ovf_i | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf_i | input | 1 | Timer 1 overflow pulse |
| ser_done_i | input | 1 | Serial transfer completion pulse |
| mf_req_i | input | 1 | Multi-function request pulse |
| phase_stb_i | input | 1 | Core phase strobe; arbitration cycle |
| stack_full_i | input | 1 | Core call stack is full |
| reti_i | input | 1 | Return-from-interrupt strobe |
| ret_i | input | 1 | Plain return strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_valid_o | output | 1 | One-cycle acceptance pulse |
| irq_vector_o | output | 8 | Vector address, valid with irq_valid_o |
| irq_ack_o | output | 1 | Push request to the core, one cycle after acceptance |

## Verification
The flag update is where two functions can land in the same cycle. A hardware request can arrive together with a software write that clears the flag. Acceptance can also coincide with a return strobe. The bench provokes the first case by driving a serial-completion pulse and a register 1 write of zero flags at the same clock edge. It then reads the register back and expects the serial flag to remain set. The priority walk is also judged under contention: all six sources pend at once, and each re-enable must yield the next vector in order. A scoreboard matches every vector pulse to the expected entry and flags any unexpected pulse.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned NSRC   = 6;
  localparam int unsigned NEXT   = 2;
  localparam int unsigned DW     = 8;
  localparam int unsigned SRC_W  = $clog2(NSRC);

  // Source index doubles as priority rank (0 = most urgent).
  typedef enum logic [SRC_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_EXT1 = 3'd1,
    SRC_TMR0 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4,
    SRC_MF   = 3'd5
  } src_e;

  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/vic_edge_sync.sv
module vic_edge_sync #(
  parameter int unsigned NPIN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  input  logic [NPIN-1:0] rise_sel_i,
  output logic [NPIN-1:0] evt_o
);
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic s1_q, s2_q, hist_q;
    logic s1_d, s2_d, hist_d;

    always_comb begin
      s1_d   = pin_i[g];
      s2_d   = s1_q;
      hist_d = s2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        hist_q <= 1'b0;
      end else begin
        s1_q   <= s1_d;
        s2_q   <= s2_d;
        hist_q <= hist_d;
      end
    end

    assign evt_o[g] = rise_sel_i[g] ? (s2_q & ~hist_q) : (~s2_q & hist_q);

    // R9
    evt_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o[g] |-> (s2_q == rise_sel_i[g]));
  end
endmodule

// File: rtl/vic_flag_regs.sv
module vic_flag_regs
  import vic_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  src_vec_t     hw_set_i,
  input  src_vec_t     acc_clr_i,
  input  logic         acc_i,
  input  logic         reti_i,
  input  logic         wr_i,
  input  logic         addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output src_vec_t     flag_o,
  output src_vec_t     en_o,
  output logic         gie_o
);
  localparam int unsigned HALF = NSRC / 2;

  src_vec_t flag_q, flag_d;
  src_vec_t en_q,   en_d;
  logic     gie_q,  gie_d;
  logic     unused_wdata;

  assign unused_wdata = wdata_i[W-1];

  always_comb begin
    flag_d = flag_q;
    en_d   = en_q;
    gie_d  = gie_q;
    if (wr_i) begin
      if (!addr_i) begin
        gie_d          = wdata_i[0];
        en_d[HALF-1:0] = wdata_i[HALF:1];
        flag_d[HALF-1:0] = wdata_i[HALF+3:4];
      end else begin
        en_d[NSRC-1:HALF]   = wdata_i[HALF-1:0];
        flag_d[NSRC-1:HALF] = wdata_i[HALF+3:4];
      end
    end
    if (reti_i) gie_d = 1'b1;
    if (acc_i)  gie_d = 1'b0;
    flag_d = (flag_d & ~acc_clr_i) | hw_set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      gie_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
      gie_q  <= gie_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!addr_i) begin
      rdata_o[0]        = gie_q;
      rdata_o[HALF:1]   = en_q[HALF-1:0];
      rdata_o[HALF+3:4] = flag_q[HALF-1:0];
    end else begin
      rdata_o[HALF-1:0] = en_q[NSRC-1:HALF];
      rdata_o[HALF+3:4] = flag_q[NSRC-1:HALF];
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign gie_o  = gie_q;

  // R10
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set_i) |=> ((flag_q & $past(hw_set_i)) == $past(hw_set_i)));

  // R7
  reti_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !acc_i) |=> gie_q);
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
#(
  parameter int unsigned VEC_BASE   = 4,
  parameter int unsigned VEC_STRIDE = 4
) (
  input  src_vec_t          req_i,
  output src_vec_t          grant_o,
  output logic              any_o,
  output logic [DW-1:0]     vector_o
);
  logic [SRC_W-1:0] idx;

  always_comb begin
    grant_o = '0;
    idx     = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx        = SRC_W'(i);
      end
    end
    any_o    = |req_i;
    vector_o = DW'(VEC_BASE) + DW'(idx) * DW'(VEC_STRIDE);
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ext_pin_i,
  input  logic [1:0]    ext_rise_sel_i,
  input  logic          tmr0_ovf_i,
  input  logic          tmr1_ovf_i,
  input  logic          ser_done_i,
  input  logic          mf_req_i,
  input  logic          phase_stb_i,
  input  logic          stack_full_i,
  input  logic          reti_i,
  input  logic          ret_i,
  input  logic          reg_wr_i,
  input  logic          reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  output logic          irq_valid_o,
  output logic [7:0]    irq_vector_o,
  output logic          irq_ack_o
);
  logic [NEXT-1:0] ext_evt;
  src_vec_t        hw_set, flag, en, req, grant, acc_clr;
  logic            gie, any_req, accept, unused_ret;
  logic [DW-1:0]   arb_vec;

  logic            valid_q, valid_d;
  logic            ack_q,   ack_d;
  logic [DW-1:0]   vec_q,   vec_d;

  // A plain return has no effect on this block's state.
  assign unused_ret = ret_i;

  vic_edge_sync #(.NPIN(NEXT)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (ext_pin_i),
    .rise_sel_i (ext_rise_sel_i),
    .evt_o      (ext_evt)
  );

  assign hw_set = {mf_req_i, ser_done_i, tmr1_ovf_i, tmr0_ovf_i, ext_evt};

  vic_flag_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_set_i  (hw_set),
    .acc_clr_i (acc_clr),
    .acc_i     (accept),
    .reti_i    (reti_i),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .flag_o    (flag),
    .en_o      (en),
    .gie_o     (gie)
  );

  assign req = flag & en;

  vic_arbiter u_arb (
    .req_i    (req),
    .grant_o  (grant),
    .any_o    (any_req),
    .vector_o (arb_vec)
  );

  assign accept  = phase_stb_i & gie & ~stack_full_i & any_req;
  assign acc_clr = accept ? grant : '0;

  always_comb begin
    valid_d = accept;
    ack_d   = valid_q;
    vec_d   = vec_q;
    if (accept) vec_d = arb_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ack_q   <= 1'b0;
      vec_q   <= '0;
    end else begin
      valid_q <= valid_d;
      ack_q   <= ack_d;
      vec_q   <= vec_d;
    end
  end

  assign irq_valid_o  = valid_q;
  assign irq_ack_o    = ack_q;
  assign irq_vector_o = vec_q;

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ($onehot(grant) && ((grant & req) == grant)));

  // R4
  no_take_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> !$past(stack_full_i));

  // R5
  gie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> !gie);

  // R8
  strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> $past(phase_stb_i));

  // R11
  ack_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |=> (irq_ack_o && !irq_valid_o));

  // R1
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (irq_vector_o[1:0] == 2'b00 && irq_vector_o >= 8'h04 && irq_vector_o <= 8'h18));
endmodule

// File: tb/vec_irq_ctrl_bench.sv
`timescale 1ns/1ps
module vec_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] ext_pin, ext_rise_sel;
  logic       tmr0, tmr1, ser, mf, stb, sfull, reti, ret;
  logic       wr, addr;
  logic [7:0] wdata, rdata, vec;
  logic       valid, ack;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] exp_q[$];
  logic prev_valid = 1'b0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl u_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .ext_rise_sel_i(ext_rise_sel),
    .tmr0_ovf_i(tmr0), .tmr1_ovf_i(tmr1), .ser_done_i(ser), .mf_req_i(mf),
    .phase_stb_i(stb), .stack_full_i(sfull), .reti_i(reti), .ret_i(ret),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_valid_o(valid), .irq_vector_o(vec), .irq_ack_o(ack)
  );

  // Monitor: pops the scoreboard on each vector pulse, checks the acknowledge.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      if (valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R4/R6/R8 unexpected vector: actual %h expected none", vec);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          if (vec !== e) begin
            fails++;
            $display("FAIL R1/R2 vector: actual %h expected %h", vec, e);
          end
        end
      end
      if (prev_valid || ack) begin
        checks++;
        if (ack !== prev_valid) begin
          fails++;
          $display("FAIL R11 ack: actual %b expected %b", ack, prev_valid);
        end
      end
      prev_valid <= valid;
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_check(input logic a, input logic [7:0] e, input string req);
    @(negedge clk); addr = a; #1;
    checks++;
    if (rdata !== e) begin
      fails++;
      $display("FAIL %s reg%0d: actual %h expected %h", req, a, rdata, e);
    end
  endtask

  task automatic strobe();
    @(negedge clk); stb = 1'b1;
    @(negedge clk); stb = 1'b0;
    step(2);
  endtask

  task automatic pulse_reti();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; ext_pin = 2'b00; ext_rise_sel = 2'b11;
    {tmr0, tmr1, ser, mf, stb, sfull, reti, ret, wr, addr} = '0;
    wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R12 reset state
    checks++;
    if (valid !== 1'b0 || ack !== 1'b0) begin
      fails++; $display("FAIL R12 outputs: actual %b%b expected 00", valid, ack);
    end
    reg_check(1'b0, 8'h00, "R12");
    reg_check(1'b1, 8'h00, "R12");

    // R3 enables and global enable written and read back
    reg_write(1'b0, 8'h0F);
    reg_write(1'b1, 8'h07);
    reg_check(1'b0, 8'h0F, "R3");
    reg_check(1'b1, 8'h07, "R3");

    // All six sources pend together; none served without a strobe (R8)
    @(negedge clk);
    ext_pin = 2'b11; tmr0 = 1; tmr1 = 1; ser = 1; mf = 1;
    @(negedge clk);
    tmr0 = 0; tmr1 = 0; ser = 0; mf = 0;
    step(4);
    reg_check(1'b0, 8'h7F, "R3 R8");
    reg_check(1'b1, 8'h77, "R3 R8");

    // R1 R2 highest first; R5 flag and global enable cleared
    exp_q.push_back(8'h04);
    strobe();
    reg_check(1'b0, 8'h6E, "R5");
    // R6 pending stays unserved while global enable clear
    strobe();
    reg_check(1'b0, 8'h6E, "R6");
    // R7 plain return leaves global enable clear
    @(negedge clk); ret = 1'b1;
    @(negedge clk); ret = 1'b0;
    reg_check(1'b0, 8'h6E, "R7");
    // R2 walk the rest in priority order
    for (int k = 1; k < 6; k++) begin
      exp_q.push_back(8'(4 + 4 * k));
      pulse_reti();
      strobe();
    end
    reg_check(1'b0, 8'h0E, "R5");
    reg_check(1'b1, 8'h07, "R5");

    // R4 stack full blocks acceptance, flag kept
    @(negedge clk); tmr0 = 1;
    @(negedge clk); tmr0 = 0;
    pulse_reti();
    sfull = 1'b1;
    strobe();
    reg_check(1'b0, 8'h4F, "R4");
    sfull = 1'b0;
    exp_q.push_back(8'h0C);
    strobe();
    reg_check(1'b0, 8'h0E, "R4");

    // R4 own enable clear blocks acceptance
    reg_write(1'b0, 8'h07);
    @(negedge clk); tmr0 = 1;
    @(negedge clk); tmr0 = 0;
    strobe();
    reg_check(1'b0, 8'h47, "R4");
    reg_write(1'b0, 8'h4F);
    exp_q.push_back(8'h0C);
    strobe();
    // R7 software sets global enable directly
    reg_write(1'b0, 8'h0F);
    reg_check(1'b0, 8'h0F, "R7");

    // R9 falling select on pin 0, rising select on pin 1
    @(negedge clk); ext_rise_sel = 2'b10; ext_pin = 2'b00;
    step(5);
    reg_check(1'b0, 8'h1F, "R9");
    @(negedge clk); ext_pin = 2'b01;
    step(5);
    reg_check(1'b0, 8'h1F, "R9");
    exp_q.push_back(8'h04);
    strobe();
    reg_check(1'b0, 8'h0E, "R9");

    // R10 hardware set beats same-cycle software clear
    @(negedge clk); wr = 1; addr = 1'b1; wdata = 8'h07; ser = 1;
    @(negedge clk); wr = 0; ser = 0;
    reg_check(1'b1, 8'h27, "R10");

    // R2 lower sources in order
    @(negedge clk); tmr1 = 1; mf = 1;
    @(negedge clk); tmr1 = 0; mf = 0;
    reg_check(1'b1, 8'h77, "R2");
    exp_q.push_back(8'h10); pulse_reti(); strobe();
    exp_q.push_back(8'h14); pulse_reti(); strobe();
    exp_q.push_back(8'h18); pulse_reti(); strobe();
    reg_check(1'b1, 8'h07, "R2");

    step(3);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R11 missing vectors: actual %0d left expected 0", exp_q.size());
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule